// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between an 8-bit CPU and three memories: a video RAM, a 16-bit-wide static RAM of 256K words, and a ROM. It decodes each 16-bit CPU address into one of four 16K windows, drives the matching chip select and address, and carries the data. The lowest window reaches ROM, the second reaches video RAM, the third always reaches RAM page 2, and the top window reaches one of 32 RAM pages chosen by software.

Software picks the top-window page by an I/O write to the paging port. The 5-bit page number comes from data bits 2..0 and 7..6 of that write. The top page bit selects the upper or lower byte lane of the 16-bit RAM, so the word-wide part holds 512K of byte storage. The same port also sets a shadow-screen select bit and a ROM bank bit. A lock bit in the port freezes all further paging until reset.

Top module: `mem_pager`

## Requirements
- R1: After reset the paging register is zero: page 0, screen select 0, ROM bank 0, and unlocked.
- R2: CPU addresses 0x0000-0x3FFF assert romCs, and romAddr equals {romBank, addr[13:0]}.
- R3: CPU addresses 0x4000-0x7FFF assert vramCs, and vramAddr equals addr[13:0].
- R4: CPU addresses 0x8000-0xBFFF assert ramCs with RAM page 2: ramAddr = {4'b0010, addr[13:0]}, lower byte lane.
- R5: CPU addresses 0xC000-0xFFFF assert ramCs with the latched page p: ramAddr = {p[3:0], addr[13:0]}, and the lane is upper when p[4]=1 and lower otherwise.
- R6: An I/O write with the full address 0x7FFD, while unlocked, latches the page as {d[7], d[6], d[2], d[1], d[0]}. That page is seen on the next cycle.
- R7: The same write sets scrSel from d[3] and romBank from d[4].
- R8: An I/O write to any other address leaves the paging register unchanged.
- R9: A write with d[5]=1 sets the lock. Later port writes have no effect until reset, and only reset clears the lock.
- R10: On a memory read from RAM, cpuDout carries ramDin[15:8] for the upper lane and ramDin[7:0] for the lower lane.
- R11: On a memory write to RAM, ramDout carries the CPU byte on both lanes, and only the selected lane's byte enable is set.
- R12: Exactly one chip select is active during a memory access, and no chip select is active otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 16 | CPU address |
| cpuDin | input | 8 | CPU write data |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| ioWr | input | 1 | I/O write strobe |
| cpuDout | output | 8 | Read data returned to the CPU |
| romCs | output | 1 | ROM select |
| romAddr | output | 15 | ROM address |
| vramCs | output | 1 | Video RAM select |
| vramAddr | output | 14 | Video RAM address |
| vramDin | input | 8 | Video RAM read data |
| romDin | input | 8 | ROM read data |
| ramCs | output | 1 | SRAM select |
| ramWe | output | 1 | SRAM write enable |
| ramAddr | output | 18 | SRAM word address |
| ramBe | output | 2 | SRAM byte enables, bit 1 is the upper lane |
| ramDout | output | 16 | SRAM write data |
| ramDin | input | 16 | SRAM read data |
| scrSel | output | 1 | Shadow-screen select, most significant bit of the screen index |
| romBank | output | 1 | ROM bank select |

## Verification
The bench builds the block with its default parameters: a 16K window, five page bits and a 7FFD port address. With these values every one of the 32 pages can be reached through the port, including pages 16 and above that switch the byte lane. A cycle-by-cycle reference model tracks the latched page and lock from the bench's own I/O writes. It predicts the select, address, enables and returned byte for each access.

// File: rtl/mem_pager_pkg.sv
package mem_pager_pkg;
  localparam int ADDR_W = 16;
  localparam int OFS_W = 14;
  localparam int PAGE_W = 5;
  typedef enum logic [1:0] {REG_ROM = 2'd0, REG_VRAM = 2'd1, REG_FIXED = 2'd2, REG_BANKED = 2'd3} region_e;
  typedef struct packed {
    logic loadEn;
  } pagerCtl_t;
  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic scr;
    logic rom;
    logic lock;
  } pageReg_t;
endpackage

// File: rtl/mem_pager_ctrl.sv
module mem_pager_ctrl
  import mem_pager_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'h7FFD
) (
  input  logic clk,
  input  logic rstN,
  input  logic [15:0] addr,
  input  logic ioWr,
  input  logic locked,
  output pagerCtl_t ctl
);
  always_comb ctl.loadEn = ioWr && (addr == PORT_ADDR) && !locked;

  // R9
  locked_no_load_chk: assert property (@(posedge clk) disable iff (!rstN) locked |-> !ctl.loadEn);
endmodule

// File: rtl/mem_pager_dp.sv
module mem_pager_dp
  import mem_pager_pkg::*;
#(
  parameter int FIXED_PAGE = 2
) (
  input  logic clk,
  input  logic rstN,
  input  pagerCtl_t ctl,
  input  logic [15:0] addr,
  input  logic [7:0] cpuDin,
  input  logic memRd,
  input  logic memWr,
  output logic locked,
  output logic [7:0] cpuDout,
  output logic romCs,
  output logic [14:0] romAddr,
  output logic vramCs,
  output logic [13:0] vramAddr,
  input  logic [7:0] vramDin,
  input  logic [7:0] romDin,
  output logic ramCs,
  output logic ramWe,
  output logic [17:0] ramAddr,
  output logic [1:0] ramBe,
  output logic [15:0] ramDout,
  input  logic [15:0] ramDin,
  output logic scrSel,
  output logic romBank
);
  pageReg_t pr;
  region_e reg_;
  logic acc, upper;
  logic [PAGE_W-1:0] effPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pr <= '0;
    else if (ctl.loadEn)
      pr <= '{page: {cpuDin[7], cpuDin[6], cpuDin[2:0]}, scr: cpuDin[3], rom: cpuDin[4], lock: cpuDin[5]};
  end

  always_comb begin
    reg_ = region_e'(addr[15:14]);
    acc = memRd | memWr;
    effPage = (reg_ == REG_BANKED) ? pr.page : PAGE_W'(FIXED_PAGE);
    upper = effPage[PAGE_W-1];
    romCs = acc && reg_ == REG_ROM;
    vramCs = acc && reg_ == REG_VRAM;
    ramCs = acc && (reg_ == REG_FIXED || reg_ == REG_BANKED);
    ramWe = ramCs && memWr;
    romAddr = {pr.rom, addr[OFS_W-1:0]};
    vramAddr = addr[OFS_W-1:0];
    ramAddr = {effPage[PAGE_W-2:0], addr[OFS_W-1:0]};
    ramBe = ramWe ? (upper ? 2'b10 : 2'b01) : 2'b00;
    ramDout = {cpuDin, cpuDin};
    case (reg_)
      REG_ROM: cpuDout = romDin;
      REG_VRAM: cpuDout = vramDin;
      default: cpuDout = upper ? ramDin[15:8] : ramDin[7:0];
    endcase
    locked = pr.lock;
    scrSel = pr.scr;
    romBank = pr.rom;
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) $past(locked) |-> locked);
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN) $past(locked) |-> $stable(pr));
  // R12
  one_cs_chk: assert property (@(posedge clk) disable iff (!rstN) $countones({romCs, vramCs, ramCs}) == (acc ? 1 : 0));
  // R11
  be_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(ramBe));
endmodule

// File: rtl/mem_pager.sv
module mem_pager
  import mem_pager_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'h7FFD,
  parameter int FIXED_PAGE = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [15:0] addr,
  input  logic [7:0] cpuDin,
  input  logic memRd,
  input  logic memWr,
  input  logic ioWr,
  output logic [7:0] cpuDout,
  output logic romCs,
  output logic [14:0] romAddr,
  output logic vramCs,
  output logic [13:0] vramAddr,
  input  logic [7:0] vramDin,
  input  logic [7:0] romDin,
  output logic ramCs,
  output logic ramWe,
  output logic [17:0] ramAddr,
  output logic [1:0] ramBe,
  output logic [15:0] ramDout,
  input  logic [15:0] ramDin,
  output logic scrSel,
  output logic romBank
);
  pagerCtl_t ctl;
  logic locked;

  mem_pager_ctrl #(.PORT_ADDR(PORT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ioWr(ioWr), .locked(locked), .ctl(ctl));

  mem_pager_dp #(.FIXED_PAGE(FIXED_PAGE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .cpuDin(cpuDin), .memRd(memRd), .memWr(memWr),
    .locked(locked), .cpuDout(cpuDout), .romCs(romCs), .romAddr(romAddr), .vramCs(vramCs),
    .vramAddr(vramAddr), .vramDin(vramDin), .romDin(romDin), .ramCs(ramCs), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramBe(ramBe), .ramDout(ramDout), .ramDin(ramDin), .scrSel(scrSel),
    .romBank(romBank));
endmodule

// File: tb/tb_mem_pager.sv
module tb_mem_pager;
  logic clk = 0, rstN = 0;
  logic [15:0] addr = 0;
  logic [7:0] cpuDin = 0, vramDin = 8'h5A, romDin = 8'hC3, cpuDout;
  logic memRd = 0, memWr = 0, ioWr = 0;
  logic romCs, vramCs, ramCs, ramWe, scrSel, romBank;
  logic [14:0] romAddr;
  logic [13:0] vramAddr;
  logic [17:0] ramAddr;
  logic [1:0] ramBe;
  logic [15:0] ramDout, ramDin = 16'hB7_4E;
  int total = 0, bad = 0;
  int mPage = 0, mScr = 0, mRom = 0, mLock = 0;

  always #2.5 clk = ~clk;

  mem_pager dut (.*);

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model update from bench's own writes
  task automatic ioWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; cpuDin = d; ioWr = 1;
    @(negedge clk); ioWr = 0;
    if (a == 16'h7FFD && mLock == 0) begin
      mPage = {d[7], d[6], d[2:0]}; mScr = d[3]; mRom = d[4]; mLock = d[5];
    end
    chk("R7", scrSel, mScr); chk("R7", romBank, mRom);
  endtask

  // one access, compared against model
  task automatic access(logic [15:0] a, bit wr);
    int pg, up;
    @(negedge clk); addr = a; memRd = !wr; memWr = wr; cpuDin = 8'h9E;
    #1;
    case (a[15:14])
      0: begin chk("R2", romCs, 1); chk("R2", romAddr, {mRom[0], a[13:0]}); chk("R12", vramCs | ramCs, 0);
         if (!wr) chk("R2", cpuDout, romDin); end
      1: begin chk("R3", vramCs, 1); chk("R3", vramAddr, a[13:0]); chk("R12", romCs | ramCs, 0);
         if (!wr) chk("R3", cpuDout, vramDin); end
      default: begin
        pg = (a[15:14] == 2) ? 2 : mPage;
        up = (pg >> 4) & 1;
        chk(a[14] ? "R5" : "R4", ramCs, 1);
        chk(a[14] ? "R5" : "R4", ramAddr, {pg[3:0], a[13:0]});
        chk("R12", romCs | vramCs, 0);
        if (wr) begin
          chk("R11", ramBe, up ? 2 : 1); chk("R11", ramDout, 16'h9E9E); chk("R11", ramWe, 1);
        end else begin
          chk("R10", cpuDout, up ? ramDin[15:8] : ramDin[7:0]); chk("R10", ramBe, 0);
        end
      end
    endcase
    memRd = 0; memWr = 0;
    #1 chk("R12", romCs | vramCs | ramCs, 0);
  endtask

  task automatic sweep();
    for (int r = 0; r < 4; r++) begin
      access(16'(r * 16'h4000 + 16'h1234), 0);
      access(16'(r * 16'h4000 + 16'h0ABC), 1);
    end
  endtask

  initial begin
    #100000; bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad); $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rstN = 1;
    // R1: reset state
    chk("R1", scrSel, 0); chk("R1", romBank, 0);
    sweep();
    // R6: all 32 pages via split bits
    for (int p = 0; p < 32; p++) begin
      ioWrite(16'h7FFD, {p[4], p[3], 3'b000, p[2:0]});
      access(16'hC000 + 16'(p), 0); access(16'hFFFF, 1);
    end
    ioWrite(16'h7FFD, 8'b1001_1011); sweep();      // R7 page 19, scr 1, rom 1
    // R8: near-miss addresses
    ioWrite(16'h7FFC, 8'h07); ioWrite(16'hFFFD, 8'h00); ioWrite(16'h7EFD, 8'hC1); sweep();
    // R9: lock then attempts
    ioWrite(16'h7FFD, 8'b0010_0110); sweep();
    ioWrite(16'h7FFD, 8'hD1); ioWrite(16'h7FFD, 8'h00); sweep();
    chk("R9", scrSel, 0);
    // reset releases lock
    @(negedge clk); rstN = 0; mPage = 0; mScr = 0; mRom = 0; mLock = 0;
    @(negedge clk); rstN = 1;
    chk("R1", scrSel, 0); sweep();
    ioWrite(16'h7FFD, 8'hC4); sweep();             // R9 unlocked after reset, page 28
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule